// File: doc/BRIEF.md
# Externally Clocked Timer/Counter

An up-counter whose count enable is taken either from a prescaler tick supplied by the surrounding timer block or from an asynchronous pin. The pin goes through a half-cycle capture stage (clocked on the falling system clock edge), a synchronizer flop and a registered edge detector. Every qualified pin edge therefore moves the count 2.5 to 3.5 system clock cycles after the edge, depending on where the edge falls relative to the clock. Pin pulses are never divided.

The counter runs free over its full range, or restarts from zero when it meets a programmed compare value. A wrap from the maximum count back to zero raises a sticky overflow interrupt request. A compare restart raises a sticky match flag. Each flag is cleared by a one-cycle clear pulse. A bus write loads the count directly. It wins over a count tick in the same cycle and masks that cycle's compare.

Top module: `ext_timer`

## Requirements
- R1: After reset, `count_o` is 0 and `ovf_irq_o`, `match_flag_o` and `top_hit_o` are 0.
- R2: With `clk_sel_i` = 2'b00 the count holds, whatever happens on `presc_tick_i` and `pin_i`.
- R3: With `clk_sel_i` = 2'b01 the count rises by one at each rising clock edge where `presc_tick_i` is high, and the new value is visible right after that edge.
- R4: With `clk_sel_i` = 2'b10 each rising edge of `pin_i` adds one. If the pin changes just after a rising clock edge, the count is updated at the third following rising clock edge and not at the second. Falling pin edges and `presc_tick_i` have no effect in this setting.
- R5: With `clk_sel_i` = 2'b11 each falling edge of `pin_i` adds one, with the same timing as R4. Rising pin edges have no effect.
- R6: With `clr_on_match_i` = 0, a tick at the maximum count (255) gives 0 and sets `ovf_irq_o`.
- R7: With `clr_on_match_i` = 1, a tick while the count equals `top_val_i` gives 0 and sets `match_flag_o`. In either mode, such a tick makes `top_hit_o` high for exactly the next cycle.
- R8: When `wr_en_i` is high, the count takes `wr_data_i` at the next edge. This holds even if a tick is present, and `top_hit_o` stays low for that cycle.
- R9: `ovf_irq_o` and `match_flag_o` stay set until a high `ovf_clr_i` or `match_clr_i` clears them. If a set and a clear fall in the same cycle, the set wins.
- R10: A pin square wave with half periods of two system clocks adds exactly one count per qualified pin edge, with no division.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous external count pin |
| presc_tick_i | input | 1 | Single-cycle tick from the prescaler |
| clk_sel_i | input | 2 | 00 stop, 01 prescaler, 10 pin rising, 11 pin falling |
| clr_on_match_i | input | 1 | 1: restart from zero on compare match |
| top_val_i | input | 8 | Compare / TOP value |
| wr_en_i | input | 1 | Bus write strobe for the count |
| wr_data_i | input | 8 | Bus write data |
| ovf_clr_i | input | 1 | Clear pulse for the overflow flag |
| match_clr_i | input | 1 | Clear pulse for the match flag |
| count_o | output | 8 | Current count |
| top_hit_o | output | 1 | One-cycle compare match pulse |
| ovf_irq_o | output | 1 | Sticky overflow interrupt request |
| match_flag_o | output | 1 | Sticky compare-restart flag |

## Verification
Prescaler ticks, writes and flag clears act at the first rising edge after they are driven, so the bench samples 1 ns after that edge. The pin path is driven 1 ns after a rising edge, which places the change ahead of the falling-edge capture. The bench checks that the count has not moved after two rising edges and has moved after the third. `top_hit_o` is checked high in the cycle right after the matching tick and low in the cycle after that.

// File: rtl/ext_timer_pkg.sv
package ext_timer_pkg;
  typedef enum logic [1:0] {
    SRC_STOP  = 2'b00,
    SRC_PRESC = 2'b01,
    SRC_RISE  = 2'b10,
    SRC_FALL  = 2'b11
  } clk_src_e;
endpackage

// File: rtl/ext_pin_sampler.sv
module ext_pin_sampler #(
  parameter int SYNC_STAGES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic              cap_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic              prev_q;
  logic              rise_q, fall_q;

  // half-cycle capture: holds the pin value sampled mid-cycle
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_q <= 1'b0;
    else         cap_q <= pin_i;
  end

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= cap_q;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      prev_q <= sync_q[SYNC_STAGES-1];
      rise_q <= sync_q[SYNC_STAGES-1] & ~prev_q;
      fall_q <= ~sync_q[SYNC_STAGES-1] & prev_q;
    end
  end

  assign rise_o = rise_q;
  assign fall_o = fall_q;
endmodule

// File: rtl/ext_tick_select.sv
module ext_tick_select
  import ext_timer_pkg::*;
(
  input  logic [1:0] clk_sel_i,
  input  logic       presc_tick_i,
  input  logic       rise_i,
  input  logic       fall_i,
  output logic       tick_o
);
  always_comb begin
    unique case (clk_src_e'(clk_sel_i))
      SRC_PRESC: tick_o = presc_tick_i;
      SRC_RISE:  tick_o = rise_i;
      SRC_FALL:  tick_o = fall_i;
      default:   tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ext_count_core.sv
module ext_count_core #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_on_match_i,
  input  logic [WIDTH-1:0] top_val_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             ovf_clr_i,
  input  logic             match_clr_i,
  output logic [WIDTH-1:0] count_o,
  output logic             top_hit_o,
  output logic             ovf_o,
  output logic             match_o
);
  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

  logic [WIDTH-1:0] cnt_q;
  logic             hit_q, ovf_q, match_q;
  logic             adv, at_top, at_max, ovf_set, match_set;

  assign adv       = tick_i & ~wr_en_i;
  assign at_top    = (cnt_q == top_val_i);
  assign at_max    = (cnt_q == CNT_MAX);
  assign ovf_set   = adv & at_max;
  assign match_set = adv & clr_on_match_i & at_top;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else if (wr_en_i) begin
      cnt_q <= wr_data_i;
      hit_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q <= (clr_on_match_i && at_top) ? '0 : cnt_q + 1'b1;
      hit_q <= at_top;
    end else begin
      hit_q <= 1'b0;
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q   <= 1'b0;
      match_q <= 1'b0;
    end else begin
      ovf_q   <= ovf_set   | (ovf_q   & ~ovf_clr_i);
      match_q <= match_set | (match_q & ~match_clr_i);
    end
  end

  assign count_o   = cnt_q;
  assign top_hit_o = hit_q;
  assign ovf_o     = ovf_q;
  assign match_o   = match_q;

  a_r8_write_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (count_o == $past(wr_data_i)) && !top_hit_o);
  a_r6_wrap_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_en_i && !clr_on_match_i && count_o == CNT_MAX) |=> (count_o == '0) && ovf_o);
  a_r7_ctc_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_en_i && clr_on_match_i && count_o == top_val_i) |=> (count_o == '0) && match_o && top_hit_o);
  a_r9_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
  a_r9_match_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !match_clr_i) |=> match_o);
  a_r7_hit_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (top_hit_o && !tick_i) |=> !top_hit_o);
endmodule

// File: rtl/ext_timer.sv
module ext_timer #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             presc_tick_i,
  input  logic [1:0]       clk_sel_i,
  input  logic             clr_on_match_i,
  input  logic [WIDTH-1:0] top_val_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             ovf_clr_i,
  input  logic             match_clr_i,
  output logic [WIDTH-1:0] count_o,
  output logic             top_hit_o,
  output logic             ovf_irq_o,
  output logic             match_flag_o
);
  logic rise, fall, tick;

  ext_pin_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  ext_tick_select u_select (
    .clk_sel_i    (clk_sel_i),
    .presc_tick_i (presc_tick_i),
    .rise_i       (rise),
    .fall_i       (fall),
    .tick_o       (tick)
  );

  ext_count_core #(.WIDTH(WIDTH)) u_core (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .tick_i         (tick),
    .clr_on_match_i (clr_on_match_i),
    .top_val_i      (top_val_i),
    .wr_en_i        (wr_en_i),
    .wr_data_i      (wr_data_i),
    .ovf_clr_i      (ovf_clr_i),
    .match_clr_i    (match_clr_i),
    .count_o        (count_o),
    .top_hit_o      (top_hit_o),
    .ovf_o          (ovf_irq_o),
    .match_o        (match_flag_o)
  );

  a_r2_stop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_i == 2'b00 && !wr_en_i) |=> $stable(count_o));
  a_r3_presc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_i == 2'b01 && presc_tick_i && !wr_en_i && !clr_on_match_i)
      |=> count_o == $past(count_o) + 1'b1);
endmodule

// File: tb/ext_timer_tb_top.sv
module ext_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0, presc = 1'b0, ctc = 1'b0, wr = 1'b0, oclr = 1'b0, mclr = 1'b0;
  logic [1:0] sel = 2'b00;
  logic [7:0] top = 8'd100, wdat = 8'd0;
  logic [7:0] cnt;
  logic       hit, ovf, mflag;
  int         total = 0, bad = 0;
  logic [7:0] exp_cnt;

  always #2.5 clk = ~clk;

  ext_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .presc_tick_i(presc),
    .clk_sel_i(sel), .clr_on_match_i(ctc), .top_val_i(top),
    .wr_en_i(wr), .wr_data_i(wdat), .ovf_clr_i(oclr), .match_clr_i(mclr),
    .count_o(cnt), .top_hit_o(hit), .ovf_irq_o(ovf), .match_flag_o(mflag)
  );

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(logic [7:0] v);
    wr = 1'b1; wdat = v;
    step();
    wr = 1'b0;
    exp_cnt = v;
  endtask

  task automatic t_reset;
    chk("R1 count", cnt, 0);
    chk("R1 ovf", ovf, 0);
    chk("R1 match", mflag, 0);
    chk("R1 hit", hit, 0);
  endtask

  task automatic t_stop;
    sel = 2'b00;
    load(8'd7);
    presc = 1'b1; step(3); presc = 1'b0;
    pin = 1'b1; step(4); pin = 1'b0; step(4);
    chk("R2 stopped", cnt, exp_cnt);
  endtask

  task automatic t_presc;
    sel = 2'b01;
    load(8'd10);
    presc = 1'b1; step(); presc = 1'b0;
    chk("R3 single tick", cnt, 11);
    step(2);
    chk("R3 no tick hold", cnt, 11);
    presc = 1'b1; step(3); presc = 1'b0;
    chk("R3 three ticks", cnt, 14);
    sel = 2'b00;
  endtask

  task automatic t_ext_rise;
    load(8'd40);
    sel = 2'b10;
    step(2);
    pin = 1'b1; step(2);
    chk("R4 not before third edge", cnt, 40);
    step();
    chk("R4 rise counted", cnt, 41);
    pin = 1'b0; step(4);
    chk("R4 fall ignored", cnt, 41);
    presc = 1'b1; step(2); presc = 1'b0;
    chk("R4 presc ignored", cnt, 41);
    sel = 2'b00;
  endtask

  task automatic t_ext_fall;
    load(8'd60);
    sel = 2'b11;
    step(2);
    pin = 1'b1; step(4);
    chk("R5 rise ignored", cnt, 60);
    pin = 1'b0; step(2);
    chk("R5 not before third edge", cnt, 60);
    step();
    chk("R5 fall counted", cnt, 61);
    sel = 2'b00;
  endtask

  task automatic t_ext_rate;
    load(8'd0);
    sel = 2'b10;
    step(2);
    for (int k = 0; k < 8; k++) begin
      pin = 1'b1; step(2);
      pin = 1'b0; step(2);
    end
    step(4);
    chk("R10 one count per edge", cnt, 8);
    sel = 2'b00;
    step(2);
  endtask

  task automatic t_wrap;
    ctc = 1'b0; top = 8'd100; sel = 2'b01;
    load(8'd254);
    presc = 1'b1; step(); presc = 1'b0;
    chk("R6 reach max", cnt, 255);
    chk("R6 no early ovf", ovf, 0);
    presc = 1'b1; step(); presc = 1'b0;
    chk("R6 wrap to zero", cnt, 0);
    chk("R6 ovf set", ovf, 1);
    step(3);
    chk("R9 ovf sticky", ovf, 1);
  endtask

  task automatic t_flag_clear;
    oclr = 1'b1; step(); oclr = 1'b0;
    chk("R9 ovf cleared", ovf, 0);
    load(8'd255);
    presc = 1'b1; oclr = 1'b1; step(); presc = 1'b0; oclr = 1'b0;
    chk("R9 set wins over clear", ovf, 1);
    oclr = 1'b1; step(); oclr = 1'b0;
    chk("R9 ovf cleared again", ovf, 0);
  endtask

  task automatic t_ctc;
    ctc = 1'b1; top = 8'd5; sel = 2'b01;
    load(8'd3);
    presc = 1'b1; step(2);
    chk("R7 count to top", cnt, 5);
    chk("R7 no hit before", hit, 0);
    step(); presc = 1'b0;
    chk("R7 restart to zero", cnt, 0);
    chk("R7 hit pulse", hit, 1);
    chk("R7 match flag", mflag, 1);
    chk("R7 no ovf", ovf, 0);
    step();
    chk("R7 hit one cycle", hit, 0);
    chk("R9 match sticky", mflag, 1);
    mclr = 1'b1; step(); mclr = 1'b0;
    chk("R9 match cleared", mflag, 0);
  endtask

  task automatic t_write_prio;
    ctc = 1'b1; top = 8'd5; sel = 2'b01;
    load(8'd5);
    presc = 1'b1; wr = 1'b1; wdat = 8'd20; step(); wr = 1'b0; presc = 1'b0;
    chk("R8 write wins", cnt, 20);
    chk("R8 hit masked", hit, 0);
    chk("R8 no match", mflag, 0);
    presc = 1'b1; step(); presc = 1'b0;
    chk("R8 count resumes", cnt, 21);
    ctc = 1'b0; sel = 2'b00;
  endtask

  initial begin
    exp_cnt = 8'd0;
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_stop();
    t_presc();
    t_ext_rise();
    t_ext_fall();
    t_ext_rate();
    t_wrap();
    t_flag_clear();
    t_ctc();
    t_write_prio();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule